// File: doc/BRIEF.md
# Machine Status Register Write Legalizer

This block keeps the machine-level status register of a processor hart and gives a reduced supervisor view of the same state. Software writes reach it through either view. The block folds each write into the stored value under fixed rules: some fields are forced, some are pinned, and the dirty-summary flag is recomputed. Both read views come back as combinational functions of the stored state. The block also produces the privilege level that data accesses must use. This level depends on the memory-privilege-override bit and the saved previous-privilege field.

The register width is always 64 bits at the ports. A static strap picks 64-bit or 32-bit layout. A second static strap, for floating-point values held in integer registers, keeps the FP state field off. Trap entry and return are handled elsewhere and only consume the fields this block exposes.

Top module: `mstat_legalizer`

## Requirements
- R1: After reset all stored fields are zero. On a 64-bit layout the machine read value is 64'h0000_000A_0000_0000, because both width fields at 35:34 and 33:32 read 2'b10. The supervisor read value is 64'h0000_0002_0000_0000.
- R2: A machine-view write stores bits 22:0 exactly as written. Bits 31:23, and on the 64-bit layout bits 62:38, read zero.
- R3: The summary flag sits in the most significant bit (63 on 64-bit, 31 on 32-bit). It is 1 exactly when any of FP state (14:13), extension state (16:15) or vector state (10:9) equals 2'b11 (Dirty; 00 Off, 01 Initial, 10 Clean). It is recomputed on every write, and the value written to that bit is ignored.
- R4: With the FP-in-integer strap set, FP state (14:13) becomes 2'b00 after every write through either view.
- R5: On the 64-bit layout, bits 37:36 read zero whatever is written. Bits 35:32 always read 4'b1010, and `sxl_o` and `uxl_o` both report 2'b10.
- R6: On the 32-bit layout, bits 63:32 of both views read zero and the summary flag moves to bit 31. `sxl_o` and `uxl_o` report 2'b01.
- R7: The supervisor read view shows only bits 0, 1, 4, 5, 8, 10:9, 14:13, 16:15, 18 and 19 (mask 0xDE733), the summary flag, and bits 33:32 on the 64-bit layout. All other bits read zero.
- R8: A supervisor-view write changes only the bits in mask 0xDE733. Machine-only bits keep their value: global enable 3, previous enable 7, previous privilege 12:11, override 17, and bits 22:20.
- R9: When both write strobes are high in the same cycle, the machine-view write takes effect and the supervisor-view data is dropped.
- R10: `eff_priv_o` equals bits 12:11 when bit 17 is 1 and the access is not an instruction fetch. In every other case it equals `priv_i`.
- R11: Without a write strobe the stored state does not change, whatever the write data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_rv64 | input | 1 | Static strap: 1 selects the 64-bit layout |
| cfg_fp_in_int | input | 1 | Static strap: FP values live in integer registers |
| wr_m | input | 1 | Write strobe, machine view |
| wr_s | input | 1 | Write strobe, supervisor view |
| wdata | input | 64 | Write data for either view |
| priv_i | input | 2 | Current privilege level |
| is_fetch | input | 1 | 1 when the access is an instruction fetch |
| m_rdata | output | 64 | Machine-view read value |
| s_rdata | output | 64 | Supervisor-view read value |
| sxl_o | output | 2 | Supervisor width code |
| uxl_o | output | 2 | User width code |
| eff_priv_o | output | 2 | Effective privilege for data accesses |

## Verification
Machine-view writes of all ones, and writes that set exactly one state field to Dirty, show which of the three fields feeds the summary flag. A write that marks every field Clean or Initial while setting the summary bit directly shows that the written flag is ignored. A supervisor write of all ones, then one of all zeros, after the machine-only bits have been set, separates correct merging from plain overwrite. Writes to the pinned upper bits, a run with the 32-bit strap, and cases where the fetch flag and override bit are each 0 and 1 cover the remaining choices.

// File: rtl/mstat_pkg.sv
// Package: shared field positions, masks and codes for the status register.
// Assumes the writable low field spans bits 22:0 in both layouts.
package mstat_pkg;
    localparam int LOW_W = 23;
    localparam int DATA_W = 64;
    localparam int NUM_EXT = 3;

    localparam int POS_FS = 13;
    localparam int POS_XS = 15;
    localparam int POS_VS = 9;
    localparam int POS_MPP = 11;
    localparam int POS_MPRV = 17;

    localparam logic [1:0] EXT_OFF = 2'b00;
    localparam logic [1:0] EXT_DIRTY = 2'b11;
    localparam logic [1:0] XL_32 = 2'b01;
    localparam logic [1:0] XL_64 = 2'b10;

    // Bits visible and writable through the supervisor view.
    localparam logic [LOW_W-1:0] SMASK = 23'h0DE733;
endpackage

// File: rtl/mstat_slift.sv
// Module: merges a supervisor-view write into the stored low field.
// Assumes the caller legalizes the merged value afterwards.
module mstat_slift
    import mstat_pkg::*;
(
    input  logic [LOW_W-1:0] old_low,
    input  logic [LOW_W-1:0] wr_low,
    output logic [LOW_W-1:0] merged_low
);
    // Keep machine-only bits, take supervisor bits from the write.
    always_comb begin
        merged_low = (old_low & ~SMASK) | (wr_low & SMASK);
    end
endmodule

// File: rtl/mstat_legal.sv
// Module: applies the machine legalization rules to a candidate low field.
// Assumes SD is carried separately and is never taken from write data.
module mstat_legal
    import mstat_pkg::*;
(
    input  logic [LOW_W-1:0] cand_low,
    input  logic             fp_in_int,
    output logic [LOW_W-1:0] legal_low,
    output logic             legal_sd
);
    localparam int EXT_LSB [NUM_EXT] = '{POS_FS, POS_XS, POS_VS};

    logic [NUM_EXT-1:0] dirty_vec;

    // Force FP state off when FP values live in integer registers.
    always_comb begin
        legal_low = cand_low;
        if (fp_in_int) begin
            legal_low[POS_FS +: 2] = EXT_OFF;
        end
    end

    // One dirty detector per extension-state field.
    for (genvar g = 0; g < NUM_EXT; g++) begin : g_dirty
        assign dirty_vec[g] = (legal_low[EXT_LSB[g] +: 2] == EXT_DIRTY);
    end

    // Summary flag is the OR of all dirty detectors.
    always_comb begin
        legal_sd = |dirty_vec;
    end
endmodule

// File: rtl/mstat_view.sv
// Module: builds both read views and the width codes from stored state.
// Assumes the layout strap is static while the block is in use.
module mstat_view
    import mstat_pkg::*;
(
    input  logic [LOW_W-1:0]  low,
    input  logic              sd,
    input  logic              rv64,
    output logic [DATA_W-1:0] m_view,
    output logic [DATA_W-1:0] s_view,
    output logic [1:0]        sxl,
    output logic [1:0]        uxl
);
    // Width codes: pinned per layout.
    always_comb begin
        sxl = rv64 ? XL_64 : XL_32;
        uxl = rv64 ? XL_64 : XL_32;
    end

    // Machine view: full low field, pinned width bits, SD in the top bit.
    always_comb begin
        m_view = '0;
        m_view[LOW_W-1:0] = low;
        if (rv64) begin
            m_view[35:34] = XL_64;
            m_view[33:32] = XL_64;
            m_view[63] = sd;
        end else begin
            m_view[31] = sd;
        end
    end

    // Supervisor view: masked low field, UXL on 64-bit, SD in the top bit.
    always_comb begin
        s_view = '0;
        s_view[LOW_W-1:0] = low & SMASK;
        if (rv64) begin
            s_view[33:32] = XL_64;
            s_view[63] = sd;
        end else begin
            s_view[31] = sd;
        end
    end
endmodule

// File: rtl/mstat_legalizer.sv
// Module: status register with machine and supervisor write views, write
// legalization and effective-privilege output.
// Assumes straps are static; a machine write wins over a supervisor write.
module mstat_legalizer
    import mstat_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_rv64,
    input  logic              cfg_fp_in_int,
    input  logic              wr_m,
    input  logic              wr_s,
    input  logic [63:0]       wdata,
    input  logic [1:0]        priv_i,
    input  logic              is_fetch,
    output logic [63:0]       m_rdata,
    output logic [63:0]       s_rdata,
    output logic [1:0]        sxl_o,
    output logic [1:0]        uxl_o,
    output logic [1:0]        eff_priv_o
);
    logic [LOW_W-1:0] low_q;
    logic             sd_q;
    logic [LOW_W-1:0] merged_low;
    logic [LOW_W-1:0] cand_low;
    logic [LOW_W-1:0] legal_low;
    logic             legal_sd;
    logic             wr_any;

    mstat_slift u_slift (
        .old_low    (low_q),
        .wr_low     (wdata[LOW_W-1:0]),
        .merged_low (merged_low)
    );

    // Pick the candidate: machine write has priority.
    always_comb begin
        wr_any = wr_m | wr_s;
        cand_low = wr_m ? wdata[LOW_W-1:0] : merged_low;
    end

    mstat_legal u_legal (
        .cand_low  (cand_low),
        .fp_in_int (cfg_fp_in_int),
        .legal_low (legal_low),
        .legal_sd  (legal_sd)
    );

    // Stored state: updated only on a write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_q <= '0;
            sd_q  <= 1'b0;
        end else if (wr_any) begin
            low_q <= legal_low;
            sd_q  <= legal_sd;
        end
    end

    mstat_view u_view (
        .low    (low_q),
        .sd     (sd_q),
        .rv64   (cfg_rv64),
        .m_view (m_rdata),
        .s_view (s_rdata),
        .sxl    (sxl_o),
        .uxl    (uxl_o)
    );

    // Effective privilege for data accesses.
    always_comb begin
        eff_priv_o = (!is_fetch && low_q[POS_MPRV]) ? low_q[POS_MPP +: 2] : priv_i;
    end

    // R3: stored summary flag agrees with the stored state fields.
    a_r3_sd_consistent: assert property (@(posedge clk) disable iff (!rst_n)
        sd_q == ((low_q[14:13] == 2'b11) || (low_q[16:15] == 2'b11) || (low_q[10:9] == 2'b11)));

    // R4: FP state is off after any write with the strap set.
    a_r4_fs_forced_off: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_any && cfg_fp_in_int) |=> (m_rdata[14:13] == 2'b00));

    // R5: pinned upper bits on the 64-bit layout.
    a_r5_upper_pinned: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rv64 |-> (m_rdata[37:32] == 6'b001010));

    // R7: supervisor view never shows machine-only bits.
    a_r7_sview_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (s_rdata[22:0] & ~SMASK) == '0 && s_rdata[62:34] == '0 && s_rdata[30:23] == '0);

    // R8: supervisor-only write leaves machine-only bits alone.
    a_r8_mbits_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_s && !wr_m) |=> ((m_rdata[22:0] & ~SMASK) == $past(m_rdata[22:0] & ~SMASK)));

    // R10: override selects the saved privilege for data accesses.
    a_r10_eff_priv: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_fetch && m_rdata[17]) |-> (eff_priv_o == m_rdata[12:11]));

    // R11: no strobe, no change.
    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_any |=> ($stable(low_q) && $stable(sd_q)));
endmodule

// File: tb/mstat_legalizer_bench.sv
// Bench: directed scenarios, one task each, expected values from requirements.
module mstat_legalizer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_rv64 = 1'b1;
    logic        cfg_fp_in_int = 1'b0;
    logic        wr_m = 1'b0;
    logic        wr_s = 1'b0;
    logic [63:0] wdata = '0;
    logic [1:0]  priv_i = 2'b11;
    logic        is_fetch = 1'b0;
    logic [63:0] m_rdata;
    logic [63:0] s_rdata;
    logic [1:0]  sxl_o;
    logic [1:0]  uxl_o;
    logic [1:0]  eff_priv_o;

    int n_checks = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    mstat_legalizer u_mstat_legalizer (
        .clk (clk), .rst_n (rst_n), .cfg_rv64 (cfg_rv64),
        .cfg_fp_in_int (cfg_fp_in_int), .wr_m (wr_m), .wr_s (wr_s),
        .wdata (wdata), .priv_i (priv_i), .is_fetch (is_fetch),
        .m_rdata (m_rdata), .s_rdata (s_rdata), .sxl_o (sxl_o),
        .uxl_o (uxl_o), .eff_priv_o (eff_priv_o)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_write(input logic m, input logic s, input logic [63:0] d);
        @(negedge clk);
        wr_m = m; wr_s = s; wdata = d;
        @(negedge clk);
        wr_m = 1'b0; wr_s = 1'b0; wdata = '0;
    endtask

    task automatic t_reset();
        chk("R1 m reset", m_rdata, 64'h0000_000A_0000_0000);
        chk("R1 s reset", s_rdata, 64'h0000_0002_0000_0000);
    endtask

    task automatic t_all_ones();
        do_write(1, 0, '1);
        chk("R2 R3 R5 m all ones", m_rdata, 64'h8000_000A_007F_FFFF);
        chk("R7 s all ones", s_rdata, 64'h8000_0002_000D_E733);
    endtask

    task automatic t_dirty_fields();
        do_write(1, 0, 64'h8000_0000_0000_C400);
        chk("R3 clean fields, written SD ignored", m_rdata, 64'h0000_000A_0000_C400);
        do_write(1, 0, 64'h0000_0000_0000_0600);
        chk("R3 VS dirty", m_rdata, 64'h8000_000A_0000_0600);
        do_write(1, 0, 64'h0000_0000_0001_8000);
        chk("R3 XS dirty", m_rdata, 64'h8000_000A_0001_8000);
        do_write(1, 0, 64'h0000_0000_0000_6000);
        chk("R3 FS dirty", m_rdata, 64'h8000_000A_0000_6000);
    endtask

    task automatic t_fp_in_int();
        cfg_fp_in_int = 1'b1;
        do_write(1, 0, 64'h0000_0000_0000_6000);
        chk("R4 machine write FS off", m_rdata, 64'h0000_000A_0000_0000);
        do_write(0, 1, 64'h0000_0000_0000_6002);
        chk("R4 supervisor write FS off", m_rdata, 64'h0000_000A_0000_0002);
        cfg_fp_in_int = 1'b0;
    endtask

    task automatic t_sview_merge();
        do_write(1, 0, 64'h0000_0000_0072_1888);
        chk("R2 machine-only bits", m_rdata, 64'h0000_000A_0072_1888);
        do_write(0, 1, '1);
        chk("R8 s write all ones", m_rdata, 64'h8000_000A_007F_FFBB);
        do_write(0, 1, '0);
        chk("R8 s write zeros", m_rdata, 64'h0000_000A_0072_1888);
        chk("R7 s view zeros", s_rdata, 64'h0000_0002_0000_0000);
    endtask

    task automatic t_both_strobes();
        do_write(1, 1, 64'h0000_0000_0000_0002);
        chk("R9 machine wins", m_rdata, 64'h0000_000A_0000_0002);
        @(negedge clk);
        wr_m = 1'b1; wr_s = 1'b1; wdata = 64'h0000_0000_0000_0001;
        @(negedge clk);
        wr_m = 1'b0; wr_s = 1'b0;
        chk("R9 same data both views", m_rdata, 64'h0000_000A_0000_0001);
    endtask

    task automatic t_pinned_upper();
        do_write(1, 0, 64'h0000_003F_0000_0000);
        chk("R5 upper pinned", m_rdata, 64'h0000_000A_0000_0000);
        chk("R5 sxl", {62'd0, sxl_o}, 64'd2);
        chk("R5 uxl", {62'd0, uxl_o}, 64'd2);
    endtask

    task automatic t_hold();
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            wdata = 64'hFFFF_FFFF_FFFF_FFFF ^ 64'(i);
        end
        @(negedge clk);
        wdata = '0;
        chk("R11 hold without strobe", m_rdata, 64'h0000_000A_0000_0000);
    endtask

    task automatic t_eff_priv();
        do_write(1, 0, 64'h0000_0000_0002_0800);
        priv_i = 2'b11; is_fetch = 1'b0; #1;
        chk("R10 override data access", {62'd0, eff_priv_o}, 64'd1);
        is_fetch = 1'b1; #1;
        chk("R10 fetch ignores override", {62'd0, eff_priv_o}, 64'd3);
        do_write(1, 0, 64'h0000_0000_0000_0800);
        is_fetch = 1'b0; priv_i = 2'b00; #1;
        chk("R10 no override", {62'd0, eff_priv_o}, 64'd0);
        priv_i = 2'b11;
    endtask

    task automatic t_rv32();
        cfg_rv64 = 1'b0;
        do_write(1, 0, '1);
        chk("R6 m 32-bit", m_rdata, 64'h0000_0000_807F_FFFF);
        chk("R6 s 32-bit", s_rdata, 64'h0000_0000_800D_E733);
        chk("R6 sxl", {62'd0, sxl_o}, 64'd1);
        chk("R6 uxl", {62'd0, uxl_o}, 64'd1);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_all_ones();
        t_dirty_fields();
        t_fp_in_int();
        t_sview_merge();
        t_both_strobes();
        t_pinned_upper();
        t_hold();
        t_eff_priv();
        t_rv32();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule